// File: doc/BRIEF.md
# Ethernet PHY Status LED Mapper

This block drives the six status LEDs of a 10/100 Ethernet PHY. Its inputs are the PHY's raw event and status lines: transmit activity, receive activity, collision, 100 Mb link, 10 Mb link, full duplex and speed. A 2-bit mapping selector picks one of four ways to route these onto the LED pins. The register that holds the selector is outside the block. So are the pin sharing with address straps and the analog LED drivers.

Activity and collision events are usually one or a few cycles long. Each one is stretched to a visible pulse of `STRETCH_CYC` clock cycles, and the default is 100 ms at 125 MHz. A new event during a running stretch starts the pulse again at its full length. One of the mappings has a combined link/activity LED. It is steadily lit while a link is up, and activity makes it blink: the LED goes dark for the first half of the stretch period and then lights again.

All inputs and the selector are sampled on the same clock edge. Every LED is decoded from that registered state, so each LED reflects the inputs one edge later.

Top module: `phy_led_mux`

## Requirements
- R1: After reset, the mapping selector holds 00 and all six LEDs are off. A new selector value applies from the first clock edge that samples it.
- R2: In every mapping, `led[5]` is the stretched receive activity, `led[4]` is the stretched transmit activity, and `led[1]` is the full-duplex status.
- R3: Selector 11: `led[3]` = link (100 Mb OR 10 Mb), `led[2]` = stretched collision, `led[0]` = speed flag (1 = 10 Mb, 0 = 100 Mb).
- R4: Selector 10: `led[3]` = link, `led[2]` = stretched any-activity, `led[0]` = speed flag.
- R5: Selector 01: `led[3]` = combined link/activity, `led[2]` = stretched collision, `led[0]` = speed flag.
- R6: Selector 00: `led[3]` = 100 Mb link, `led[2]` = stretched any-activity, `led[0]` = 10 Mb link.
- R7: An event sampled high at a clock edge makes its stretched signal high from that edge for exactly `STRETCH_CYC` cycles.
- R8: An event sampled while its stretch is running restarts the stretch, so the signal stays high for `STRETCH_CYC` cycles after the latest event.
- R9: The combined link/activity signal works as follows:
  - With link up and no activity stretch running, it is on.
  - With link up after an activity event, it is off for the first `STRETCH_CYC - STRETCH_CYC/2` cycles of the stretch, then on.
  - With no link, it follows the stretched any-activity signal.
- R10: Any-activity is the OR of transmit and receive activity, taken before stretching. A receive-only or a transmit-only event triggers it.
- R11: Link, speed and duplex status reach the LEDs one clock edge after they are sampled, with no stretching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_sel | input | 2 | LED mapping selector |
| tx_evt | input | 1 | Transmit activity event |
| rx_evt | input | 1 | Receive activity event |
| col_evt | input | 1 | Collision event |
| link_100 | input | 1 | 100 Mb link detected |
| link_10 | input | 1 | 10 Mb link detected |
| full_dup | input | 1 | Full duplex enabled |
| spd_10 | input | 1 | 1 when running at 10 Mb, 0 at 100 Mb |
| led | output | 6 | LED drive, bit 5 down to bit 0 |

## Verification
Every LED is due one clock edge after the inputs that cause it are sampled, and this holds for events, status and the selector alike. The bench drives inputs on the falling edge. It advances its own model on the rising edge and compares all six LEDs on the next falling edge. The model is built from the requirements. Stretch length, restart and blink timing are also counted in directed runs: the bench counts how many falling-edge samples an LED stays high or low after a single event, and compares that count with `STRETCH_CYC` and its halves.

// File: rtl/phy_led_mux.sv
module phy_led_mux #(
  parameter int unsigned STRETCH_CYC = 12_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] map_sel,
  input  logic       tx_evt,
  input  logic       rx_evt,
  input  logic       col_evt,
  input  logic       link_100,
  input  logic       link_10,
  input  logic       full_dup,
  input  logic       spd_10,
  output logic [5:0] led
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);
  localparam logic [CW-1:0] HALF = CW'(STRETCH_CYC / 2);

  // stretcher index: 0 rx, 1 tx, 2 any activity, 3 collision
  logic [3:0]    evt;
  logic [CW-1:0] cnt [4];
  logic [3:0]    str;
  logic [1:0]    sel_q;
  logic          l100_q, l10_q, fdx_q, spd_q;
  logic          link, lnk_act;

  assign evt = {col_evt, tx_evt | rx_evt, tx_evt, rx_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) cnt[i] <= '0;
      sel_q  <= 2'b00;
      l100_q <= 1'b0;
      l10_q  <= 1'b0;
      fdx_q  <= 1'b0;
      spd_q  <= 1'b0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (evt[i])            cnt[i] <= LOAD;
        else if (cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
      end
      sel_q  <= map_sel;
      l100_q <= link_100;
      l10_q  <= link_10;
      fdx_q  <= full_dup;
      spd_q  <= spd_10;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_str
    assign str[g] = (cnt[g] != '0);
  end

  assign link    = l100_q | l10_q;
  assign lnk_act = link ? (cnt[2] <= HALF) : str[2];

  always_comb begin
    led[5] = str[0];
    led[4] = str[1];
    led[1] = fdx_q;
    unique case (sel_q)
      2'b11:   begin led[3] = link;    led[2] = str[3]; led[0] = spd_q; end
      2'b10:   begin led[3] = link;    led[2] = str[2]; led[0] = spd_q; end
      2'b01:   begin led[3] = lnk_act; led[2] = str[3]; led[0] = spd_q; end
      default: begin led[3] = l100_q;  led[2] = str[2]; led[0] = l10_q; end
    endcase
  end

  assert_sel_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sel_q == 2'b00));
  assert_rx_led_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> led[5]);
  assert_fdx_led_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> led[1]);
  assert_tx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> (cnt[1] == LOAD));
  assert_col_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_evt && cnt[3] != '0) |=> (cnt[3] == LOAD));
  assert_any_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt || rx_evt) |=> str[2]);
  assert_steady_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b01 && link && cnt[2] == '0) |-> led[3]);
  assert_blink_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_100 || link_10) && (tx_evt || rx_evt) && map_sel == 2'b01 && STRETCH_CYC > 1)
      |=> !led[3]);
endmodule

// File: tb/phy_led_mux_bench.sv
module phy_led_mux_bench;
  localparam int N = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] map_sel = 2'b00;
  logic tx_evt = 0, rx_evt = 0, col_evt = 0, link_100 = 0, link_10 = 0, full_dup = 0, spd_10 = 0;
  logic [5:0] led;
  int vectors = 0, errors = 0;
  bit done = 0;

  // model state
  logic [1:0] m_sel;
  logic m_l100, m_l10, m_fdx, m_spd;
  int m_c [4];

  always #4 clk = ~clk;

  phy_led_mux #(.STRETCH_CYC(N)) u_phy_led_mux (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .col_evt(col_evt), .link_100(link_100), .link_10(link_10), .full_dup(full_dup),
    .spd_10(spd_10), .led(led));

  function automatic logic [5:0] exp_led();
    logic [5:0] e;
    logic lk, la;
    lk = m_l100 | m_l10;
    la = lk ? (m_c[2] <= N / 2) : (m_c[2] != 0);
    e[5] = m_c[0] != 0;
    e[4] = m_c[1] != 0;
    e[1] = m_fdx;
    case (m_sel)
      2'b11:   begin e[3] = lk;     e[2] = m_c[3] != 0; e[0] = m_spd; end
      2'b10:   begin e[3] = lk;     e[2] = m_c[2] != 0; e[0] = m_spd; end
      2'b01:   begin e[3] = la;     e[2] = m_c[3] != 0; e[0] = m_spd; end
      default: begin e[3] = m_l100; e[2] = m_c[2] != 0; e[0] = m_l10;  end
    endcase
    return e;
  endfunction

  function automatic string tag(int b, logic [1:0] s);
    if (b == 5 || b == 4 || b == 1) return "R2";
    if (b == 3 && s == 2'b01) return "R9";
    case (s)
      2'b11: return "R3";
      2'b10: return "R4";
      2'b01: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic [3:0] ev;
    logic [5:0] e;
    @(posedge clk);
    ev = {col_evt, tx_evt | rx_evt, tx_evt, rx_evt};
    if (!rst_n) begin
      m_sel = 0; m_l100 = 0; m_l10 = 0; m_fdx = 0; m_spd = 0;
      for (int i = 0; i < 4; i++) m_c[i] = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (ev[i]) m_c[i] = N; else if (m_c[i] != 0) m_c[i]--;
      m_sel = map_sel; m_l100 = link_100; m_l10 = link_10; m_fdx = full_dup; m_spd = spd_10;
    end
    @(negedge clk);
    e = exp_led();
    vectors++;
    for (int b = 0; b < 6; b++)
      if (led[b] !== e[b]) begin
        errors++;
        $display("FAIL %s: led[%0d] actual %0b expected %0b (sel %b) at %0t",
                 tag(b, m_sel), b, led[b], e[b], m_sel, $time);
      end
  endtask

  task automatic quiet(int n);
    tx_evt = 0; rx_evt = 0; col_evt = 0;
    repeat (n) cycle();
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_1ED5));
    repeat (3) cycle();
    chk(led === 6'b0, "R1", led, 0);
    rst_n = 1'b1;
    cycle();
    chk(led === 6'b0, "R1", led, 0);

    // R11: status passes with one edge of latency, mode 00
    full_dup = 1; link_10 = 1;
    cycle();
    chk(led[1] === 1'b1 && led[0] === 1'b1, "R11", {led[1], led[0]}, 3);
    // R1: new selector applies on the next edge
    map_sel = 2'b11; spd_10 = 1;
    cycle();
    chk(led[3] === 1'b1 && led[0] === 1'b1, "R1", {led[3], led[0]}, 3);

    // R7: single transmit pulse length
    tx_evt = 1; cycle(); tx_evt = 0;
    n = (led[4] === 1'b1) ? 1 : 0;
    while (led[4] === 1'b1 && n < 4 * N) begin cycle(); if (led[4] === 1'b1) n++; end
    chk(n == N, "R7", n, N);

    // R8: restart after 5 cycles keeps it high N cycles from the second event
    col_evt = 1; cycle(); col_evt = 0; quiet(5);
    col_evt = 1; cycle(); col_evt = 0;
    n = (led[2] === 1'b1) ? 1 : 0;
    while (led[2] === 1'b1 && n < 4 * N) begin cycle(); if (led[2] === 1'b1) n++; end
    chk(n == N, "R8", n, N);

    // R10: receive-only event lights any-activity in mode 10
    map_sel = 2'b10; quiet(2);
    rx_evt = 1; cycle(); rx_evt = 0;
    chk(led[2] === 1'b1, "R10", led[2], 1);
    quiet(N + 2);
    chk(led[2] === 1'b0, "R10", led[2], 0);

    // R9: blink timing with link up
    map_sel = 2'b01; link_100 = 1; quiet(3);
    chk(led[3] === 1'b1, "R9", led[3], 1);
    tx_evt = 1; cycle(); tx_evt = 0;
    n = (led[3] === 1'b0) ? 1 : 0;
    while (led[3] === 1'b0 && n < 4 * N) begin cycle(); if (led[3] === 1'b0) n++; end
    chk(n == N - N / 2, "R9", n, N - N / 2);
    // R9: no link, follows activity stretch
    link_100 = 0; link_10 = 0; quiet(N + 2);
    chk(led[3] === 1'b0, "R9", led[3], 0);
    rx_evt = 1; cycle(); rx_evt = 0;
    chk(led[3] === 1'b1, "R9", led[3], 1);

    // R5: collision in mode 01
    col_evt = 1; cycle(); col_evt = 0;
    chk(led[2] === 1'b1, "R5", led[2], 1);

    // R3 R4 R5 R6: random mix checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      tx_evt  = ($urandom % 16) == 0;
      rx_evt  = ($urandom % 12) == 0;
      col_evt = ($urandom % 40) == 0;
      if (($urandom % 64) == 0) link_100 = $urandom;
      if (($urandom % 64) == 0) link_10  = $urandom;
      if (($urandom % 64) == 0) full_dup = $urandom;
      if (($urandom % 64) == 0) spd_10   = $urandom;
      if (($urandom % 150) == 0) map_sel = 2'($urandom);
      cycle();
    end
    quiet(N + 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule